// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block accepts interrupts for 256 numbered vectors and decides which one the processor takes next. Each vector has three state bits: a request bit, an in-service bit, and a trigger-mode bit that records whether the last request was level or edge triggered. The number of a vector is also its priority, so the highest set bit always wins. The top four bits of a vector number form its priority class.

A four-bit task priority, written by the processor, is combined with the class of the highest in-service vector to give a processor priority. The interrupt line to the processor rises only when the controller is enabled and the class of the best pending request is above that processor priority. An acknowledge either moves the best request into service and returns its number, or returns the programmed spurious vector and leaves the request bits alone. An end-of-interrupt retires the highest in-service vector. One 9-bit control register holds both the enable bit and the spurious vector. A query port reads the three state bits of any one vector.

Top module: `vic_top`

## Requirements
- R1: An accepted acknowledge returns the highest-numbered vector whose request bit is set.
- R2: A set-interrupt request sets the request bit of its vector, and writes that vector's trigger-mode bit to 1 for level trigger and 0 for edge trigger. Acknowledge and end-of-interrupt leave the trigger-mode bit unchanged.
- R3: `irqPending` is low whenever control bit 8 (enable) is 0, and whenever no request bit is set.
- R4: While enabled, `irqPending` is low if the processor priority is nonzero and bits 7:4 of the highest request are less than or equal to bits 7:4 of the processor priority. Otherwise it is high.
- R5: If the task priority is nonzero and the highest request is less than or equal to the task priority, an acknowledge returns control bits 7:0 and leaves every request bit unchanged. The comparison uses all 8 bits.
- R6: An accepted acknowledge clears the request bit of the returned vector and sets its in-service bit. The state changes on the clock edge that samples `ackReq`.
- R7: End-of-interrupt clears the highest set in-service bit. With no in-service bit set, it changes nothing.
- R8: The control register takes all 9 bits on a write and resets to 0x0FF. The block therefore comes up disabled with spurious vector 0xFF.
- R9: A task-priority write of value v sets the task priority to v<<4. `tprRead` returns v from the next cycle on.
- R10: Reset clears every request, in-service and trigger-mode bit, and drives `irqPending` and `procPriority` to 0.
- R11: The processor priority equals the task priority when its bits 7:4 are greater than or equal to bits 7:4 of the highest in-service vector. Otherwise it equals that vector with bits 3:0 cleared. An empty in-service set counts as class 0.
- R12: An acknowledge returns the spurious vector, with no state change, when no request bit is set or when the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setValid | input | 1 | Raise the request for `setVector` |
| setVector | input | 8 | Vector being requested |
| setLevel | input | 1 | 1 = level trigger, 0 = edge trigger |
| ackReq | input | 1 | Processor acknowledge strobe |
| eoiReq | input | 1 | End-of-interrupt strobe |
| ctlWrite | input | 1 | Write strobe for the control register |
| ctlWdata | input | 9 | Bit 8 enable, bits 7:0 spurious vector |
| tprWrite | input | 1 | Write strobe for the task priority |
| tprWdata | input | 4 | Task priority class |
| queryVector | input | 8 | Vector whose state bits are shown on the query outputs |
| irqPending | output | 1 | Interrupt request to the processor |
| ackVector | output | 8 | Vector that an acknowledge in this cycle returns |
| procPriority | output | 8 | Current processor priority |
| tprRead | output | 4 | Task priority class readback |
| queryIrr | output | 1 | Request bit of `queryVector` |
| queryIsr | output | 1 | In-service bit of `queryVector` |
| queryTmr | output | 1 | Trigger-mode bit of `queryVector` |

## Verification
The hardest case to reach is one where the class test and the full-vector test disagree. The task priority masks the pending line because the request sits in the same class, yet an acknowledge still accepts the vector because its low nibble is above the task priority. A second hard case is a masked acknowledge that must return the spurious vector without touching the requests. To reach both, the stimulus first fills two requests in class 4 at different low nibbles. It then steps the task priority through classes 4, 5 and 0 while a class-4 vector is in service, so the processor priority switches between the task value and the in-service class. A later re-enable shows that a request survived spurious acknowledges, both the one with nothing pending and the one made while disabled.

// File: rtl/vic_pkg.sv
package vic_pkg;
  parameter int VIC_VEC_W = 8;

  typedef struct packed {
    logic                 doSet;
    logic                 setLevel;
    logic [VIC_VEC_W-1:0] setVec;
    logic                 doAccept;
    logic [VIC_VEC_W-1:0] acceptVec;
    logic                 doEoi;
    logic [VIC_VEC_W-1:0] eoiVec;
  } vic_strobe_t;
endpackage

// File: rtl/vic_prienc.sv
module vic_prienc #(
  parameter int N = 256,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] bits,
  output logic [W-1:0] top,
  output logic         any
);
  // Highest set bit wins: later iterations overwrite earlier ones.
  always_comb begin
    top = '0;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) top = W'(i);
    end
    any = |bits;
  end
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int NUM_VEC = 2 ** VIC_VEC_W,
  localparam int VW = VIC_VEC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  vic_strobe_t       strb,
  input  logic [VW-1:0]     queryVector,
  output logic [NUM_VEC-1:0] irrBits,
  output logic [NUM_VEC-1:0] isrBits,
  output logic [VW-1:0]     irrHi,
  output logic              irrAny,
  output logic [VW-1:0]     isrHi,
  output logic              isrAny,
  output logic              queryIrr,
  output logic              queryIsr,
  output logic              queryTmr
);
  logic [NUM_VEC-1:0] tmrBits;

  // Clear first, then set, so a same-cycle set of a vector wins.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irrBits <= '0;
      isrBits <= '0;
      tmrBits <= '0;
    end else begin
      if (strb.doAccept) irrBits[strb.acceptVec] <= 1'b0;
      if (strb.doSet) begin
        irrBits[strb.setVec] <= 1'b1;
        tmrBits[strb.setVec] <= strb.setLevel;
      end
      if (strb.doEoi)    isrBits[strb.eoiVec]    <= 1'b0;
      if (strb.doAccept) isrBits[strb.acceptVec] <= 1'b1;
    end
  end

  vic_prienc #(.N(NUM_VEC), .W(VW)) u_irrEnc (.bits(irrBits), .top(irrHi), .any(irrAny));
  vic_prienc #(.N(NUM_VEC), .W(VW)) u_isrEnc (.bits(isrBits), .top(isrHi), .any(isrAny));

  assign queryIrr = irrBits[queryVector];
  assign queryIsr = isrBits[queryVector];
  assign queryTmr = tmrBits[queryVector];
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int CLS_W = 4,
  localparam int VW = VIC_VEC_W,
  localparam int CLS_LSB = VW - CLS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setValid,
  input  logic [VW-1:0]     setVector,
  input  logic              setLevel,
  input  logic              ackReq,
  input  logic              eoiReq,
  input  logic              ctlWrite,
  input  logic [VW:0]       ctlWdata,
  input  logic              tprWrite,
  input  logic [CLS_W-1:0]  tprWdata,
  input  logic [VW-1:0]     irrHi,
  input  logic              irrAny,
  input  logic [VW-1:0]     isrHi,
  input  logic              isrAny,
  output vic_strobe_t       strb,
  output logic [VW:0]       ctlReg,
  output logic              irqPending,
  output logic [VW-1:0]     ackVector,
  output logic [VW-1:0]     procPriority,
  output logic [CLS_W-1:0]  tprRead
);
  logic [VW-1:0] tprReg;
  logic [VW-1:0] isrClass;
  logic          enabled;
  logic          accept;
  logic          classBlocked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg <= {1'b0, {VW{1'b1}}};
      tprReg <= '0;
    end else begin
      if (ctlWrite) ctlReg <= ctlWdata;
      if (tprWrite) tprReg <= {tprWdata, {CLS_LSB{1'b0}}};
    end
  end

  assign enabled  = ctlReg[VW];
  assign isrClass = isrAny ? {isrHi[VW-1:CLS_LSB], {CLS_LSB{1'b0}}} : '0;

  always_comb begin
    if (tprReg[VW-1:CLS_LSB] >= isrClass[VW-1:CLS_LSB]) procPriority = tprReg;
    else                                                procPriority = isrClass;
  end

  assign classBlocked = (procPriority != '0) &&
                        (irrHi[VW-1:CLS_LSB] <= procPriority[VW-1:CLS_LSB]);
  assign irqPending   = enabled && irrAny && !classBlocked;

  assign accept    = enabled && irrAny && !((tprReg != '0) && (irrHi <= tprReg));
  assign ackVector = accept ? irrHi : ctlReg[VW-1:0];
  assign tprRead   = tprReg[VW-1:CLS_LSB];

  always_comb begin
    strb.doSet     = setValid;
    strb.setLevel  = setLevel;
    strb.setVec    = setVector;
    strb.doAccept  = ackReq && accept;
    strb.acceptVec = irrHi;
    strb.doEoi     = eoiReq && isrAny;
    strb.eoiVec    = isrHi;
  end
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int NUM_VEC = 2 ** VIC_VEC_W,
  parameter int CLS_W   = 4,
  localparam int VW = VIC_VEC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             setValid,
  input  logic [VW-1:0]    setVector,
  input  logic             setLevel,
  input  logic             ackReq,
  input  logic             eoiReq,
  input  logic             ctlWrite,
  input  logic [VW:0]      ctlWdata,
  input  logic             tprWrite,
  input  logic [CLS_W-1:0] tprWdata,
  input  logic [VW-1:0]    queryVector,
  output logic             irqPending,
  output logic [VW-1:0]    ackVector,
  output logic [VW-1:0]    procPriority,
  output logic [CLS_W-1:0] tprRead,
  output logic             queryIrr,
  output logic             queryIsr,
  output logic             queryTmr
);
  vic_strobe_t        strb;
  logic [VW:0]        ctlReg;
  logic [NUM_VEC-1:0] irrBits, isrBits;
  logic [VW-1:0]      irrHi, isrHi;
  logic               irrAny, isrAny;

  vic_ctrl #(.CLS_W(CLS_W)) u_ctrl (
    .clk, .rstN, .setValid, .setVector, .setLevel, .ackReq, .eoiReq,
    .ctlWrite, .ctlWdata, .tprWrite, .tprWdata,
    .irrHi, .irrAny, .isrHi, .isrAny,
    .strb, .ctlReg, .irqPending, .ackVector, .procPriority, .tprRead
  );

  vic_datapath #(.NUM_VEC(NUM_VEC)) u_dp (
    .clk, .rstN, .strb, .queryVector,
    .irrBits, .isrBits, .irrHi, .irrAny, .isrHi, .isrAny,
    .queryIrr, .queryIsr, .queryTmr
  );
endmodule

// File: rtl/vic_checker.sv
module vic_checker
  import vic_pkg::*;
#(
  parameter int NUM_VEC = 2 ** VIC_VEC_W,
  parameter int CLS_W   = 4,
  localparam int VW = VIC_VEC_W
) (
  input logic               clk,
  input logic               rstN,
  input logic               setValid,
  input logic               ackReq,
  input logic               tprWrite,
  input logic [CLS_W-1:0]   tprWdata,
  input logic [CLS_W-1:0]   tprRead,
  input logic               irqPending,
  input logic [VW-1:0]      ackVector,
  input logic [VW-1:0]      procPriority,
  input logic [VW:0]        ctlReg,
  input vic_strobe_t        strb,
  input logic [NUM_VEC-1:0] irrBits,
  input logic [NUM_VEC-1:0] isrBits
);
  p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctlReg[VW] |-> !irqPending);

  p_spurious_keeps_irr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && !strb.doAccept && !setValid) |=> (irrBits == $past(irrBits)));

  p_accept_moves_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doAccept && !setValid) |=> (isrBits[$past(ackVector)] && !irrBits[$past(ackVector)]));

  p_eoi_retires_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doEoi && !strb.doAccept) |=> !isrBits[$past(strb.eoiVec)]);

  p_tpr_echo_r9: assert property (@(posedge clk) disable iff (!rstN)
    tprWrite |=> (tprRead == $past(tprWdata)));

  p_ppr_floor_r11: assert property (@(posedge clk) disable iff (!rstN)
    procPriority[VW-1 -: CLS_W] >= tprRead);
endmodule

bind vic_top vic_checker #(.NUM_VEC(NUM_VEC), .CLS_W(CLS_W)) u_chk (
  .clk(clk), .rstN(rstN), .setValid(setValid), .ackReq(ackReq),
  .tprWrite(tprWrite), .tprWdata(tprWdata), .tprRead(tprRead),
  .irqPending(irqPending), .ackVector(ackVector), .procPriority(procPriority),
  .ctlReg(ctlReg), .strb(strb), .irrBits(irrBits), .isrBits(isrBits)
);

// File: tb/vic_top_tb.sv
module vic_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       setValid = 0, setLevel = 0, ackReq = 0, eoiReq = 0;
  logic       ctlWrite = 0, tprWrite = 0;
  logic [7:0] setVector = 0, queryVector = 0;
  logic [8:0] ctlWdata = 0;
  logic [3:0] tprWdata = 0;
  logic       irqPending, queryIrr, queryIsr, queryTmr;
  logic [7:0] ackVector, procPriority;
  logic [3:0] tprRead;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  vic_top u_dut (
    .clk, .rstN, .setValid, .setVector, .setLevel, .ackReq, .eoiReq,
    .ctlWrite, .ctlWdata, .tprWrite, .tprWdata, .queryVector,
    .irqPending, .ackVector, .procPriority, .tprRead,
    .queryIrr, .queryIsr, .queryTmr
  );

  localparam logic [2:0] OP_SET = 3'd1, OP_ACK = 3'd2, OP_EOI = 3'd3,
                         OP_CTL = 3'd4, OP_TPR = 3'd5;
  localparam int NSTEP = 23;
  // {op, arg[8:0], level, expected pending, expected priority, expected ack vector}
  localparam logic [29:0] STEPS [NSTEP] = '{
    {OP_CTL, 9'h13F, 1'b0, 1'b0, 8'h00, 8'h00},
    {OP_SET, 9'h045, 1'b0, 1'b1, 8'h00, 8'h00},
    {OP_SET, 9'h092, 1'b1, 1'b1, 8'h00, 8'h00},
    {OP_SET, 9'h047, 1'b0, 1'b1, 8'h00, 8'h00},
    {OP_ACK, 9'h000, 1'b0, 1'b0, 8'h90, 8'h92},
    {OP_SET, 9'h0A1, 1'b0, 1'b1, 8'h90, 8'h00},
    {OP_ACK, 9'h000, 1'b0, 1'b0, 8'hA0, 8'hA1},
    {OP_EOI, 9'h000, 1'b0, 1'b0, 8'h90, 8'h00},
    {OP_EOI, 9'h000, 1'b0, 1'b1, 8'h00, 8'h00},
    {OP_TPR, 9'h004, 1'b0, 1'b0, 8'h40, 8'h00},
    {OP_ACK, 9'h000, 1'b0, 1'b0, 8'h40, 8'h47},
    {OP_TPR, 9'h005, 1'b0, 1'b0, 8'h50, 8'h00},
    {OP_ACK, 9'h000, 1'b0, 1'b0, 8'h50, 8'h3F},
    {OP_TPR, 9'h000, 1'b0, 1'b0, 8'h40, 8'h00},
    {OP_EOI, 9'h000, 1'b0, 1'b1, 8'h00, 8'h00},
    {OP_ACK, 9'h000, 1'b0, 1'b0, 8'h40, 8'h45},
    {OP_EOI, 9'h000, 1'b0, 1'b0, 8'h00, 8'h00},
    {OP_EOI, 9'h000, 1'b0, 1'b0, 8'h00, 8'h00},
    {OP_ACK, 9'h000, 1'b0, 1'b0, 8'h00, 8'h3F},
    {OP_SET, 9'h020, 1'b0, 1'b1, 8'h00, 8'h00},
    {OP_CTL, 9'h03F, 1'b0, 1'b0, 8'h00, 8'h00},
    {OP_ACK, 9'h000, 1'b0, 1'b0, 8'h00, 8'h3F},
    {OP_CTL, 9'h13F, 1'b0, 1'b1, 8'h00, 8'h00}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic clearInputs();
    setValid = 0; ackReq = 0; eoiReq = 0; ctlWrite = 0; tprWrite = 0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 / R8: reset state
    check(irqPending, 0, "R10 pending after reset");
    check(procPriority, 0, "R10 priority after reset");
    check(tprRead, 0, "R9 task readback after reset");
    check(ackVector, 8'hFF, "R8 reset spurious vector");
    rstN = 1;

    // table walk: R1 R3 R4 R5 R6 R7 R11 R12
    for (int i = 0; i < NSTEP; i++) begin
      logic [2:0] op;
      logic [8:0] arg;
      op  = STEPS[i][29:27];
      arg = STEPS[i][26:18];
      @(negedge clk);
      case (op)
        OP_SET: begin setValid = 1; setVector = arg[7:0]; setLevel = STEPS[i][17]; end
        OP_ACK: ackReq = 1;
        OP_EOI: eoiReq = 1;
        OP_CTL: begin ctlWrite = 1; ctlWdata = arg; end
        OP_TPR: begin tprWrite = 1; tprWdata = arg[3:0]; end
        default: ;
      endcase
      #5;
      if (op == OP_ACK)
        check(ackVector, STEPS[i][7:0], $sformatf("R1 R5 R12 ack vector step %0d", i));
      @(posedge clk);
      #1 clearInputs();
      @(negedge clk);
      check(irqPending, STEPS[i][16], $sformatf("R3 R4 pending step %0d", i));
      check(procPriority, STEPS[i][15:8], $sformatf("R11 R7 priority step %0d", i));
    end

    // R2: trigger-mode bits survive acknowledge and end-of-interrupt
    queryVector = 8'h92; #2;
    check(queryTmr, 1, "R2 level vector keeps trigger bit");
    check(queryIsr, 0, "R7 retired vector not in service");
    queryVector = 8'h45; #2;
    check(queryTmr, 0, "R2 edge vector trigger bit");
    queryVector = 8'h20; #2;
    check(queryIrr, 1, "R5 request kept through spurious acks");

    // R2: edge request after level request clears trigger bit
    @(negedge clk); setValid = 1; setVector = 8'h92; setLevel = 0;
    @(posedge clk); #1 clearInputs();
    @(negedge clk); queryVector = 8'h92; #2;
    check(queryTmr, 0, "R2 edge overwrite of trigger bit");
    check(queryIrr, 1, "R2 request bit set");

    // R9: task priority write and readback
    @(negedge clk); tprWrite = 1; tprWdata = 4'hC;
    @(posedge clk); #1 clearInputs();
    @(negedge clk);
    check(tprRead, 4'hC, "R9 readback");
    check(procPriority, 8'hC0, "R9 shifted task priority");
    check(irqPending, 0, "R4 masked by task class");

    // R6: acknowledge with task class C accepts nothing below C0 -> spurious
    #2 check(ackVector, 8'h3F, "R5 ack below task priority");

    // R10: reset mid-run clears state
    @(negedge clk); rstN = 0;
    @(posedge clk); #1;
    @(negedge clk);
    queryVector = 8'h92; #2;
    check(queryIrr, 0, "R10 request cleared");
    check(queryTmr, 0, "R10 trigger cleared");
    queryVector = 8'h20; #2;
    check(queryIrr, 0, "R10 request cleared second");
    check(irqPending, 0, "R10 pending low");
    check(procPriority, 0, "R10 priority zero");
    check(ackVector, 8'hFF, "R8 spurious restored by reset");
    rstN = 1;

    // R6: accept moves request into service
    @(negedge clk); ctlWrite = 1; ctlWdata = 9'h1FF;
    @(posedge clk); #1 clearInputs();
    @(negedge clk); setValid = 1; setVector = 8'h33; setLevel = 1;
    @(posedge clk); #1 clearInputs();
    @(negedge clk); ackReq = 1; #2;
    check(ackVector, 8'h33, "R1 single request returned");
    @(posedge clk); #1 clearInputs();
    @(negedge clk); queryVector = 8'h33; #2;
    check(queryIrr, 0, "R6 request cleared");
    check(queryIsr, 1, "R6 in-service set");
    check(queryTmr, 1, "R2 level trigger bit");
    check(procPriority, 8'h30, "R11 in-service class");

    finish();
  end
endmodule